// File: doc/BRIEF.md
# Lockstep Discrepancy Classifier

This block watches two copies of one module that run side by side on the same replayed stimulus. One copy is a trusted reference. The other may carry an injected bit-flip. On every qualified sample the block compares the two copies' primary outputs bit by bit, and it compares their full internal register state. It keeps a running record of what differed. When the run is closed, it grades the outcome into one of three levels.

The first grade means nothing differed. The second grade is a latent fault: the internal state diverged at some point, but no output ever did. The third grade is output damage, and for that grade a per-output mask names the outputs that went wrong. The block also records the sample index of the first output disagreement, so the faulty run can be replayed and examined from that point.

A run closes on the sample that carries the end marker. The next run opens on the first sample or end marker after that. The grade holds steady between those two events.

Top module: `lsc_top`

## Requirements
- R1: While reset is asserted and right after it is released, `class_vld_o` is 0, `class_o` is 0, `out_mask_o` is all zeros and `first_hit_o` is 0.
- R2: Bit i of `out_mask_o` is set once output bit i of the two copies has disagreed on any qualified sample of the current run. It stays set until the next run opens. It is updated on the clock edge that takes the sample.
- R3: A closed run in which any output bit disagreed is graded 2 (output damage), and its `out_mask_o` is non-zero.
- R4: A closed run in which the internal state disagreed at least once, and no output ever did, is graded 1 (latent). This holds even when the state agreed again before the run closed.
- R5: A closed run with no disagreement of any kind is graded 0 (no effect), and `class_vld_o` is still raised.
- R6: `first_cyc_o` holds the zero-based index, among the qualified samples of the run, of the first sample with an output disagreement, and `first_hit_o` is 1. Later disagreements do not change `first_cyc_o`. The sample counter saturates at its maximum.
- R7: `class_vld_o` is 1 in the cycle after `run_end_i` is sampled high. It stays 1, and `class_o` stays constant, until the next run opens.
- R8: Data presented with `smp_vld_i` low is ignored. It changes neither the mask, nor the first-disagreement record, nor the latent record, nor the sample count.
- R9: A qualified sample or an end marker arriving while `class_vld_o` is 1 opens a new run. The open clears all records and lowers `class_vld_o` (unless the same cycle also ends the run), and that sample becomes index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld_i | input | 1 | Current sample is qualified for comparison |
| run_end_i | input | 1 | Current cycle closes the run |
| gold_out_i | input | OUT_W | Reference copy outputs |
| dut_out_i | input | OUT_W | Fault-injected copy outputs |
| gold_st_i | input | ST_W | Reference copy register state |
| dut_st_i | input | ST_W | Fault-injected copy register state |
| class_o | output | 2 | Run grade: 0 none, 1 latent, 2 output damage |
| class_vld_o | output | 1 | Grade is final |
| out_mask_o | output | OUT_W | Sticky per-output disagreement mask |
| first_cyc_o | output | CYC_W | Index of first output disagreement |
| first_hit_o | output | 1 | An output disagreement has been recorded |

## Verification
The assertions check on every cycle that the grade becomes final after an end marker and then holds. They check that the mask only ever gains bits within a run, and that a grade of 2 always comes with a non-empty mask and the reverse. They also check that idle cycles and later disagreements leave the first-disagreement record alone. The directed scenarios are needed to show the rest. They show that the correct grade is chosen for clean, latent and damaging runs, including a latent divergence that heals before the run closes. They also show the exact mask bits and first-disagreement index, and that a new run clears the records left by the previous one.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  typedef enum logic [1:0] {
    CLS_CLEAN  = 2'd0,
    CLS_LATENT = 2'd1,
    CLS_OUTDMG = 2'd2
  } cls_e;
endpackage

// File: rtl/lsc_diff.sv
// Per-sample comparison: output bit differences and a lane-folded state mismatch.
module lsc_diff #(
  parameter int OUT_W  = 32,
  parameter int ST_W   = 64,
  parameter int LANE_W = 16
) (
  input  logic             smp_vld_i,
  input  logic [OUT_W-1:0] gold_out_i,
  input  logic [OUT_W-1:0] dut_out_i,
  input  logic [ST_W-1:0]  gold_st_i,
  input  logic [ST_W-1:0]  dut_st_i,
  output logic [OUT_W-1:0] out_diff_o,
  output logic             st_miss_o
);
  localparam int N_LANE = (ST_W + LANE_W - 1) / LANE_W;
  localparam int PAD_W  = N_LANE * LANE_W;

  logic [PAD_W-1:0]  st_x;
  logic [N_LANE-1:0] lane_hit;

  always_comb begin
    st_x = '0;
    st_x[ST_W-1:0] = gold_st_i ^ dut_st_i;
  end

  for (genvar i = 0; i < N_LANE; i++) begin : g_lane
    assign lane_hit[i] = |st_x[i*LANE_W +: LANE_W];
  end

  assign out_diff_o = smp_vld_i ? (gold_out_i ^ dut_out_i) : '0;
  assign st_miss_o  = smp_vld_i & (|lane_hit);
endmodule

// File: rtl/lsc_accum.sv
// Run records: sticky mask, latent flag, sample counter, first output hit.
module lsc_accum #(
  parameter int OUT_W = 32,
  parameter int CYC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_vld_i,
  input  logic             start_i,
  input  logic [OUT_W-1:0] out_diff_i,
  input  logic             st_miss_i,
  output logic [OUT_W-1:0] mask_q_o,
  output logic [OUT_W-1:0] mask_d_o,
  output logic             lat_d_o,
  output logic [CYC_W-1:0] first_q_o,
  output logic             hit_q_o
);
  localparam logic [CYC_W-1:0] CNT_MAX = '1;

  logic [OUT_W-1:0] mask_q, mask_d;
  logic             lat_q, lat_d;
  logic [CYC_W-1:0] cnt_q, cnt_d, cnt_base;
  logic [CYC_W-1:0] first_q, first_d;
  logic             hit_q, hit_d, hit_base;
  logic             en;

  always_comb begin
    en       = smp_vld_i | start_i;
    mask_d   = (start_i ? '0 : mask_q) | out_diff_i;
    lat_d    = (start_i ? 1'b0 : lat_q) | st_miss_i;
    cnt_base = start_i ? '0 : cnt_q;
    hit_base = start_i ? 1'b0 : hit_q;
    first_d  = start_i ? '0 : first_q;
    hit_d    = hit_base;
    if ((|out_diff_i) && !hit_base) begin
      first_d = cnt_base;
      hit_d   = 1'b1;
    end
    cnt_d = cnt_base;
    if (smp_vld_i && (cnt_base != CNT_MAX)) cnt_d = cnt_base + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      lat_q   <= 1'b0;
      cnt_q   <= '0;
      first_q <= '0;
      hit_q   <= 1'b0;
    end else if (en) begin
      mask_q  <= mask_d;
      lat_q   <= lat_d;
      cnt_q   <= cnt_d;
      first_q <= first_d;
      hit_q   <= hit_d;
    end
  end

  assign mask_q_o  = mask_q;
  assign mask_d_o  = mask_d;
  assign lat_d_o   = lat_d;
  assign first_q_o = first_q;
  assign hit_q_o   = hit_q;
endmodule

// File: rtl/lsc_classify.sv
// Run closure and grading.
module lsc_classify
  import lsc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run_end_i,
  input  logic start_i,
  input  logic dmg_any_i,
  input  logic lat_i,
  output logic done_o,
  output cls_e cls_o
);
  logic done_q, done_d;
  cls_e cls_q, cls_d, grade;
  logic en;

  always_comb begin
    if (dmg_any_i)  grade = CLS_OUTDMG;
    else if (lat_i) grade = CLS_LATENT;
    else            grade = CLS_CLEAN;
    en     = run_end_i | start_i;
    done_d = run_end_i ? 1'b1 : 1'b0;
    cls_d  = run_end_i ? grade : CLS_CLEAN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      cls_q  <= CLS_CLEAN;
    end else if (en) begin
      done_q <= done_d;
      cls_q  <= cls_d;
    end
  end

  assign done_o = done_q;
  assign cls_o  = cls_q;
endmodule

// File: rtl/lsc_top.sv
module lsc_top
  import lsc_pkg::*;
#(
  parameter int OUT_W  = 32,
  parameter int ST_W   = 64,
  parameter int LANE_W = 16,
  parameter int CYC_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_vld_i,
  input  logic             run_end_i,
  input  logic [OUT_W-1:0] gold_out_i,
  input  logic [OUT_W-1:0] dut_out_i,
  input  logic [ST_W-1:0]  gold_st_i,
  input  logic [ST_W-1:0]  dut_st_i,
  output logic [1:0]       class_o,
  output logic             class_vld_o,
  output logic [OUT_W-1:0] out_mask_o,
  output logic [CYC_W-1:0] first_cyc_o,
  output logic             first_hit_o
);
  logic [OUT_W-1:0] out_diff, mask_q, mask_d;
  logic             st_miss, lat_d, done, start;
  cls_e             cls;

  assign start = done & (smp_vld_i | run_end_i);

  lsc_diff #(.OUT_W(OUT_W), .ST_W(ST_W), .LANE_W(LANE_W)) u_diff (
    .smp_vld_i (smp_vld_i),
    .gold_out_i(gold_out_i),
    .dut_out_i (dut_out_i),
    .gold_st_i (gold_st_i),
    .dut_st_i  (dut_st_i),
    .out_diff_o(out_diff),
    .st_miss_o (st_miss)
  );

  lsc_accum #(.OUT_W(OUT_W), .CYC_W(CYC_W)) u_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_vld_i (smp_vld_i),
    .start_i   (start),
    .out_diff_i(out_diff),
    .st_miss_i (st_miss),
    .mask_q_o  (mask_q),
    .mask_d_o  (mask_d),
    .lat_d_o   (lat_d),
    .first_q_o (first_cyc_o),
    .hit_q_o   (first_hit_o)
  );

  lsc_classify u_cls (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_end_i(run_end_i),
    .start_i  (start),
    .dmg_any_i(|mask_d),
    .lat_i    (lat_d),
    .done_o   (done),
    .cls_o    (cls)
  );

  assign class_o     = cls;
  assign class_vld_o = done;
  assign out_mask_o  = mask_q;
endmodule

// File: rtl/lsc_checker.sv
module lsc_checker #(
  parameter int OUT_W = 32,
  parameter int CYC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_vld_i,
  input logic             run_end_i,
  input logic [1:0]       class_o,
  input logic             class_vld_o,
  input logic [OUT_W-1:0] out_mask_o,
  input logic [CYC_W-1:0] first_cyc_o,
  input logic             first_hit_o
);
  assert_final_after_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_end_i |=> class_vld_o);

  assert_grade_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (class_vld_o && !smp_vld_i && !run_end_i) |=> (class_vld_o && $stable(class_o)));

  assert_dmg_has_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (class_vld_o && class_o == 2'd2) |-> (out_mask_o != '0));

  assert_mask_means_dmg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (class_vld_o && out_mask_o != '0) |-> (class_o == 2'd2));

  assert_legal_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    class_o != 2'd3);

  assert_mask_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !class_vld_o |=> ((out_mask_o & $past(out_mask_o)) == $past(out_mask_o)));

  assert_idle_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_vld_i && !run_end_i) |=> ($stable(out_mask_o) && $stable(first_cyc_o) && $stable(first_hit_o)));

  assert_first_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (first_hit_o && !class_vld_o) |=> (first_hit_o && $stable(first_cyc_o)));

  assert_new_run_opens_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (class_vld_o && smp_vld_i && !run_end_i) |=> !class_vld_o);
endmodule

bind lsc_top lsc_checker #(.OUT_W(OUT_W), .CYC_W(CYC_W)) u_lsc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .smp_vld_i  (smp_vld_i),
  .run_end_i  (run_end_i),
  .class_o    (class_o),
  .class_vld_o(class_vld_o),
  .out_mask_o (out_mask_o),
  .first_cyc_o(first_cyc_o),
  .first_hit_o(first_hit_o)
);

// File: tb/test_lsc_top.sv
module test_lsc_top;
  localparam int OUT_W = 32;
  localparam int ST_W  = 64;
  localparam int CYC_W = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             smp_vld_i, run_end_i;
  logic [OUT_W-1:0] gold_out_i, dut_out_i;
  logic [ST_W-1:0]  gold_st_i, dut_st_i;
  logic [1:0]       class_o;
  logic             class_vld_o;
  logic [OUT_W-1:0] out_mask_o;
  logic [CYC_W-1:0] first_cyc_o;
  logic             first_hit_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  lsc_top #(.OUT_W(OUT_W), .ST_W(ST_W), .LANE_W(16), .CYC_W(CYC_W)) i_lsc_top (
    .clk(clk), .rst_n(rst_n), .smp_vld_i(smp_vld_i), .run_end_i(run_end_i),
    .gold_out_i(gold_out_i), .dut_out_i(dut_out_i),
    .gold_st_i(gold_st_i), .dut_st_i(dut_st_i),
    .class_o(class_o), .class_vld_o(class_vld_o), .out_mask_o(out_mask_o),
    .first_cyc_o(first_cyc_o), .first_hit_o(first_hit_o)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge; outputs are read at the next falling edge.
  task automatic step(input logic vld, input logic fin, input logic [OUT_W-1:0] oflip,
                      input logic [ST_W-1:0] sflip);
    smp_vld_i  = vld;
    run_end_i  = fin;
    gold_out_i = 32'h1234_5678;
    dut_out_i  = 32'h1234_5678 ^ oflip;
    gold_st_i  = 64'hDEAD_BEEF_0BAD_F00D;
    dut_st_i   = 64'hDEAD_BEEF_0BAD_F00D ^ sflip;
    @(posedge clk);
    @(negedge clk);
    smp_vld_i = 1'b0;
    run_end_i = 1'b0;
    dut_out_i = gold_out_i;
    dut_st_i  = gold_st_i;
  endtask

  task automatic t_reset();
    chk("R1", "class_vld", {63'd0, class_vld_o}, 64'd0);
    chk("R1", "class", {62'd0, class_o}, 64'd0);
    chk("R1", "mask", {32'd0, out_mask_o}, 64'd0);
    chk("R1", "first_hit", {63'd0, first_hit_o}, 64'd0);
  endtask

  task automatic t_clean();
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, '0, '0);
    chk("R7", "vld before end", {63'd0, class_vld_o}, 64'd0);
    step(1'b1, 1'b1, '0, '0);
    chk("R7", "vld after end", {63'd0, class_vld_o}, 64'd1);
    chk("R5", "clean grade", {62'd0, class_o}, 64'd0);
    chk("R5", "clean mask", {32'd0, out_mask_o}, 64'd0);
  endtask

  task automatic t_latent_heal();
    step(1'b1, 1'b0, '0, '0);
    chk("R9", "vld drops on new run", {63'd0, class_vld_o}, 64'd0);
    step(1'b1, 1'b0, '0, 64'h0001_0000_0000_0000);
    step(1'b1, 1'b0, '0, '0);
    step(1'b1, 1'b1, '0, '0);
    chk("R4", "healed latent grade", {62'd0, class_o}, 64'd1);
    chk("R4", "latent mask empty", {32'd0, out_mask_o}, 64'd0);
    chk("R4", "latent no first hit", {63'd0, first_hit_o}, 64'd0);
  endtask

  task automatic t_damage();
    step(1'b1, 1'b0, '0, '0);                    // index 0
    step(1'b1, 1'b0, 32'h0000_0008, 64'h1);      // index 1: bit 3
    chk("R6", "first index", {48'd0, first_cyc_o}, 64'd1);
    chk("R2", "mask after bit3", {32'd0, out_mask_o}, 64'h8);
    step(1'b0, 1'b0, 32'h00F0_0000, 64'hF);      // not qualified
    chk("R8", "idle mask", {32'd0, out_mask_o}, 64'h8);
    step(1'b1, 1'b0, 32'h8000_0000, '0);         // index 2: bit 31
    step(1'b1, 1'b0, 32'h0000_0008, '0);         // index 3: bit 3 again
    chk("R6", "first kept", {48'd0, first_cyc_o}, 64'd1);
    step(1'b1, 1'b1, '0, '0);                    // index 4, end
    chk("R3", "damage grade", {62'd0, class_o}, 64'd2);
    chk("R2", "final mask", {32'd0, out_mask_o}, 64'h8000_0008);
    chk("R6", "first hit", {63'd0, first_hit_o}, 64'd1);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 32'hFFFF_FFFF, '1);
    chk("R7", "grade held", {62'd0, class_o}, 64'd2);
    chk("R7", "vld held", {63'd0, class_vld_o}, 64'd1);
    chk("R8", "mask held idle", {32'd0, out_mask_o}, 64'h8000_0008);
  endtask

  task automatic t_new_run_clears();
    step(1'b1, 1'b0, 32'h0000_0100, '0);         // index 0 of new run
    chk("R9", "mask restarted", {32'd0, out_mask_o}, 64'h100);
    chk("R9", "first index zero", {48'd0, first_cyc_o}, 64'd0);
    chk("R9", "vld low", {63'd0, class_vld_o}, 64'd0);
    step(1'b1, 1'b1, '0, '0);
    chk("R3", "grade after restart", {62'd0, class_o}, 64'd2);
  endtask

  task automatic t_unqualified();
    step(1'b1, 1'b0, '0, '0);
    step(1'b0, 1'b0, 32'hFFFF_FFFF, '1);
    step(1'b0, 1'b0, 32'h0F0F_0F0F, 64'h55);
    step(1'b1, 1'b1, '0, '0);
    chk("R8", "unqualified grade", {62'd0, class_o}, 64'd0);
    chk("R8", "unqualified mask", {32'd0, out_mask_o}, 64'd0);
    chk("R8", "unqualified hit", {63'd0, first_hit_o}, 64'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    smp_vld_i = 1'b0; run_end_i = 1'b0;
    gold_out_i = '0; dut_out_i = '0; gold_st_i = '0; dut_st_i = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_latent_heal();
    t_damage();
    t_new_run_clears();
    t_unqualified();
    finished = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk);
      if (finished) break;
    end
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule